// File: doc/BRIEF.md
# Real-Time Counter with Tear-Free Seconds Snapshot

This block keeps wall time as two counters advanced by a reference tick: a sub-second counter that runs through one thousand steps per second, and a 32-bit seconds counter that advances each time the sub-second counter wraps. Software reads them over a small memory-mapped bus with one read and one write strobe.

Two separate bus reads cannot sample two counters at the same instant, so a seconds carry can fall between them. The block avoids this with a snapshot: every read of the sub-second register also copies the seconds count into a shadow register in the same clock edge. A later read of the shadow register then returns the seconds value that belongs with the sub-second value already read. Software forms a timestamp in milliseconds as `subsec + shadow * 1000`. The live seconds register can be read directly and can be loaded by a bus write.

Top module: `rtc_snap_timer`

## Requirements
- R1: After a synchronous reset, seconds, sub-second count, shadow and `rdata` are all zero.
- R2: Each cycle with `tick` high advances the sub-second count by one. Without a tick it holds. The count always stays within 0 to MS_PER_S-1 (default 999).
- R3: A tick at sub-second value MS_PER_S-1 sets the sub-second count to 0 and adds one to seconds on the same edge.
- R4: Seconds counts modulo 2^32, so a carry from 0xFFFFFFFF gives 0.
- R5: A read at byte offset 0x10 returns the sub-second count and copies the seconds count into the shadow on the same edge. The shadow is read at offset 0x0C. Reading 0x10 first and 0x0C afterwards gives a consistent pair.
- R6: The shadow changes only on a read of offset 0x10. Ticks, carries and seconds writes leave it unchanged.
- R7: If a tick and a read of offset 0x10 fall in the same cycle, the returned sub-second value and the snapshot seconds are both the values after that tick, including a wrap into the next second.
- R8: A write to offset 0x08 loads seconds with `wdata`, and a read of 0x08 returns the live seconds. When a load and a carry coincide, the written value wins, and the sub-second count still follows R2/R3.
- R9: Writes to 0x10, 0x0C or any unmapped offset change nothing. A read of an unmapped offset returns 0.
- R10: `rdata` is registered. It shows the read result in the cycle after `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick, one millisecond step per high cycle |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
A wrong snapshot shows up on the next shadow read as a timestamp, `subsec + shadow*1000`, that differs from the number of ticks issued. A missed carry gives an error of exactly 1000. A shadow disturbed by ticks gives a value that moved since the last sub-second read. Counter faults appear one cycle after the read that exposes them, because `rdata` has a single register stage. Reads are timed to land exactly on wrap boundaries, and the bench also checks a load that coincides with a carry, so a one-edge ordering error between tick, load and snapshot changes a returned value.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam logic [31:0] OFS_SECONDS = 32'h08;
  localparam logic [31:0] OFS_SHADOW  = 32'h0C;
  localparam logic [31:0] OFS_SUBSEC  = 32'h10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SECONDS,
    SEL_SHADOW,
    SEL_SUBSEC
  } rtc_sel_e;

  function automatic rtc_sel_e rtc_decode(input logic [31:0] a);
    rtc_sel_e s;
    case (a)
      OFS_SECONDS: s = SEL_SECONDS;
      OFS_SHADOW:  s = SEL_SHADOW;
      OFS_SUBSEC:  s = SEL_SUBSEC;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rtc_snap_subsec.sv
module rtc_snap_subsec #(
  parameter int MS_PER_S = 1000,
  localparam int MS_W = $clog2(MS_PER_S)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [MS_W-1:0] ms_q,
  output logic [MS_W-1:0] ms_nxt,
  output logic            carry
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_S - 1);

  always_comb begin
    carry  = tick && (ms_q == MS_LAST);
    ms_nxt = ms_q;
    if (carry)     ms_nxt = '0;
    else if (tick) ms_nxt = ms_q + MS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) ms_q <= '0;
    else     ms_q <= ms_nxt;
  end
endmodule

// File: rtl/rtc_snap_seconds.sv
module rtc_snap_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             carry,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] sec_q,
  output logic [SEC_W-1:0] sec_nxt
);
  always_comb begin
    if (load)       sec_nxt = load_val;
    else if (carry) sec_nxt = sec_q + SEC_W'(1);
    else            sec_nxt = sec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sec_q <= '0;
    else     sec_q <= sec_nxt;
  end
endmodule

// File: rtl/rtc_snap_shadow.sv
module rtc_snap_shadow #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             snap,
  input  logic [SEC_W-1:0] sec_nxt,
  output logic [SEC_W-1:0] shadow_q
);
  always_ff @(posedge clk) begin
    if (rst)       shadow_q <= '0;
    else if (snap) shadow_q <= sec_nxt;
  end
endmodule

// File: rtl/rtc_snap_timer.sv
module rtc_snap_timer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int SEC_W    = 32,
  parameter int MS_PER_S = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import rtc_snap_pkg::*;

  localparam int MS_W = $clog2(MS_PER_S);

  rtc_sel_e         sel;
  logic             load, snap, carry;
  logic [MS_W-1:0]  ms_q, ms_nxt;
  logic [SEC_W-1:0] sec_q, sec_nxt, shadow_q;
  logic [DATA_W-1:0] rd_val;

  assign sel  = rtc_decode(32'(addr));
  assign load = wr_en && (sel == SEL_SECONDS);
  assign snap = rd_en && (sel == SEL_SUBSEC);

  rtc_snap_subsec #(.MS_PER_S(MS_PER_S)) u_subsec (
    .clk(clk), .rst(rst), .tick(tick),
    .ms_q(ms_q), .ms_nxt(ms_nxt), .carry(carry)
  );

  rtc_snap_seconds #(.SEC_W(SEC_W)) u_seconds (
    .clk(clk), .rst(rst), .carry(carry), .load(load),
    .load_val(wdata[SEC_W-1:0]), .sec_q(sec_q), .sec_nxt(sec_nxt)
  );

  rtc_snap_shadow #(.SEC_W(SEC_W)) u_shadow (
    .clk(clk), .rst(rst), .snap(snap),
    .sec_nxt(sec_nxt), .shadow_q(shadow_q)
  );

  always_comb begin
    case (sel)
      SEL_SECONDS: rd_val = DATA_W'(sec_nxt);
      SEL_SUBSEC:  rd_val = DATA_W'(ms_nxt);
      SEL_SHADOW:  rd_val = DATA_W'(shadow_q);
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/rtc_snap_checker.sv
module rtc_snap_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int SEC_W    = 32,
  parameter int MS_PER_S = 1000,
  localparam int MS_W = $clog2(MS_PER_S)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [MS_W-1:0]   ms_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [SEC_W-1:0]  shadow_q
);
  import rtc_snap_pkg::*;

  logic is_sub, is_sec, is_none;
  assign is_sub  = rtc_decode(32'(addr)) == SEL_SUBSEC;
  assign is_sec  = rtc_decode(32'(addr)) == SEL_SECONDS;
  assign is_none = rtc_decode(32'(addr)) == SEL_NONE;

  p_ms_range_r2: assert property (@(posedge clk) disable iff (rst)
    32'(ms_q) < MS_PER_S);

  p_ms_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ms_q));

  p_wrap_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && 32'(ms_q) == MS_PER_S - 1 && !(wr_en && is_sec))
      |=> (ms_q == '0) && (sec_q == $past(sec_q) + SEC_W'(1)));

  p_snap_match_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_sub) |=> shadow_q == sec_q);

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && is_sub) |=> $stable(shadow_q));

  p_sec_load_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_sec) |=> sec_q == $past(wdata[SEC_W-1:0]));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_none) |=> rdata == '0);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind rtc_snap_timer rtc_snap_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_PER_S(MS_PER_S)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata),
  .ms_q(ms_q), .sec_q(sec_q), .shadow_q(shadow_q)
);

// File: tb/test_rtc_snap_timer.sv
module test_rtc_snap_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_SEC = 8'h08, A_SH = 8'h0C, A_MS = 8'h10, A_BAD = 8'h40;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_cmp = 0, n_bad = 0;
  longint unsigned e_ms = 0, e_sec = 0, e_sh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_snap_timer i_rtc_snap_timer (
    .clk(clk), .rst(rst), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit rd, input bit wr,
                      input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tick = t; rd_en = rd; wr_en = wr; addr = a; wdata = d;
    @(posedge clk);
    #1;
    if (t) begin
      if (e_ms == 999) begin e_ms = 0; e_sec = (e_sec + 1) % 64'h1_0000_0000; end
      else e_ms++;
    end
    if (wr && a == A_SEC) e_sec = d;
    if (rd && a == A_MS) e_sh = e_sec;
  endtask

  task automatic to_last_ms();
    while (e_ms != 999) step(1, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    longint unsigned held, tot;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 rdata after reset", rdata, 0);
    step(0, 1, 0, A_SEC, 0); check("R1 seconds after reset", rdata, 0);
    step(0, 1, 0, A_SH, 0);  check("R1 shadow after reset", rdata, 0);

    // R2 R3 R5 R7: sweep ticks, read subsec then shadow, timestamp equals tick count
    tot = 0;
    for (int i = 1; i <= 2600; i++) begin
      bit rd_now;
      tot++;
      rd_now = (tot % 97 == 0) || (tot % 1000 == 0) || (tot % 1000 == 999);
      step(1, rd_now, 0, rd_now ? A_MS : 8'h00, 0);
      if (rd_now) begin
        check("R2/R7 subsec with tick", rdata, tot % 1000);
        step(0, 1, 0, A_SH, 0);
        check("R5 shadow pairs with subsec", rdata, tot / 1000);
        check("R3 timestamp", rdata * 1000 + (tot % 1000), tot);
      end
    end
    step(0, 1, 0, A_SEC, 0); check("R3 live seconds", rdata, tot / 1000);

    // R6: shadow unaffected by ticks, carries, seconds writes
    step(0, 1, 0, A_MS, 0); held = e_sh;
    repeat (1200) step(1, 0, 0, 8'h00, 0);
    step(0, 0, 1, A_SEC, 32'h0000_0777);
    step(0, 1, 0, A_SH, 0); check("R6 shadow held", rdata, held);

    // R8: load coinciding with carry wins; subsec still wraps
    to_last_ms();
    step(1, 0, 1, A_SEC, 32'h0000_1234);
    step(0, 1, 0, A_MS, 0); check("R8 subsec wrapped under load", rdata, 0);
    step(0, 1, 0, A_SH, 0); check("R8 load wins over carry", rdata, 32'h1234);
    step(0, 1, 1, A_SEC, 32'hCAFE_0001); check("R8 seconds read returns write", rdata, 32'hCAFE_0001);

    // R4 R7: seconds wrap with snapshot on the same edge as the tick
    step(0, 0, 1, A_SEC, 32'hFFFF_FFFF);
    to_last_ms();
    step(1, 1, 0, A_MS, 0); check("R7 subsec post-wrap", rdata, 0);
    step(0, 1, 0, A_SH, 0); check("R4 seconds modulo 2^32", rdata, 0);

    // R9: writes to read-only and unmapped offsets ignored
    repeat (5) step(1, 0, 0, 8'h00, 0);
    step(0, 0, 1, A_MS, 32'h0000_0055);
    step(0, 0, 1, A_SH, 32'h0000_0066);
    step(0, 0, 1, A_BAD, 32'h0000_0077);
    step(0, 1, 0, A_SEC, 0); check("R9 seconds untouched", rdata, e_sec);
    step(0, 1, 0, A_SH, 0);  check("R9 shadow untouched", rdata, e_sh);
    step(0, 1, 0, A_MS, 0);  check("R9 subsec untouched", rdata, e_ms);
    step(0, 1, 0, A_BAD, 0); check("R9 unmapped read zero", rdata, 0);

    // R10: rdata holds while rd_en low
    step(0, 1, 0, A_MS, 0); held = rdata;
    step(1, 0, 0, A_SEC, 0);
    step(1, 0, 1, A_SEC, 32'h0000_0042);
    step(0, 0, 0, A_BAD, 0);
    check("R10 rdata holds", rdata, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule